// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns one ALU operation into a registered 16-bit status word. On every clock edge where an update is requested it looks at the two operands, the result and the carry/borrow out of the ALU, and from them derives six condition flags: carry, parity, auxiliary (nibble) carry, zero, sign and signed overflow. Each operation is worked out at either byte or word width, as the width select says. The same word also holds three control flags (single-step, interrupt enable, string direction). These move only on explicit set and clear commands and never follow ALU results.

The ALU datapath sits beside the block and feeds it the operands, the result it computed, its carry out and an operation class. The class tells the block how each flag must be formed. Add and subtract use the ALU carry/borrow. Logic operations clear carry and overflow. Increment and decrement treat the second operand as one and keep the previous carry. The flag word is read straight from the block's output one cycle after the operation is presented.

Top module: `aluflag_top`

## Requirements
- R1: While reset is held and right after it, the flag word reads 0x0002: all nine flags are clear and bit 1 is set.
- R2: Carry is bit 0. After ADD (op_class 0) or SUB (1) it equals alu_cout, the carry or borrow out of the selected width. LOGIC (2) clears it. INC (3) and DEC (4) leave it unchanged and ignore alu_cout.
- R3: Parity is bit 2. It is set when bits 7:0 of the result hold an even number of ones, and this is true at both widths.
- R4: Auxiliary carry is bit 4. It is set on a carry out of bit 3 for ADD and INC, or on a borrow into bit 4 for SUB and DEC. LOGIC clears it.
- R5: Zero is bit 6. It is set when the result is all zeros over the selected width: bits 7:0 when wide_sel is 0, bits 15:0 when wide_sel is 1. Bits 15:8 are ignored in byte mode.
- R6: Sign is bit 7. It copies result bit 7 in byte mode and result bit 15 in word mode.
- R7: Overflow is bit 11. It is set when the signed result of ADD, SUB, INC or DEC does not fit the selected width. LOGIC clears it.
- R8: When upd_en is 0, or op_class is 5, 6 or 7, the six condition flags keep their values.
- R9: Control flags sit at bit 8 (TF), bit 9 (IF) and bit 10 (DF). They are driven by ctl_set and ctl_clr, whose bits 0, 1 and 2 select TF, IF and DF. Set wins over clear. With neither command a control flag holds, whatever the ALU inputs are.
- R10: Bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand (not used for INC/DEC) |
| alu_result | input | 16 | Result computed by the ALU |
| alu_cout | input | 1 | Carry or borrow out of the selected width |
| op_class | input | 3 | 0 ADD, 1 SUB, 2 LOGIC, 3 INC, 4 DEC, others no update |
| wide_sel | input | 1 | 0 byte width, 1 word width |
| upd_en | input | 1 | Update the condition flags this cycle |
| ctl_set | input | 3 | Set commands for TF, IF, DF (bits 0, 1, 2) |
| ctl_clr | input | 3 | Clear commands for TF, IF, DF (bits 0, 1, 2) |
| flag_word | output | 16 | Registered status word |

## Verification
The assertions assume that alu_result and alu_cout really belong to the operands and operation class presented with them, and that op_class is stable within a cycle. They do not try to check the arithmetic itself. For that reason the stimulus computes each result and carry from the operands inside the bench before driving it. It drives an inverted carry only on increment and decrement, where that input must be ignored, and fills the upper result byte with unrelated bits in byte mode. The control commands are exercised apart from, and together with, ALU updates, including set and clear asserted in the same cycle.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_LOGIC = 3'd2,
    OPC_INC   = 3'd3,
    OPC_DEC   = 3'd4
  } opclass_e;

  localparam int FW      = 16;
  localparam int B_CY    = 0;
  localparam int B_ONE   = 1;
  localparam int B_PAR   = 2;
  localparam int B_AC    = 4;
  localparam int B_ZR    = 6;
  localparam int B_SG    = 7;
  localparam int B_TRAP  = 8;
  localparam int B_INTEN = 9;
  localparam int B_DIR   = 10;
  localparam int B_OV    = 11;
  localparam int NCTL    = 3;
  localparam int NIB     = 4;

  typedef struct packed {
    logic ov;
    logic sg;
    logic zr;
    logic ac;
    logic par;
    logic cy;
  } cond_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic signed_ovf(input logic sub, input logic am,
                                      input logic bm, input logic rm);
    if (sub) return (am != bm) && (rm != am);
    return (am == bm) && (rm != am);
  endfunction

endpackage

// File: rtl/aluflag_calc.sv
module aluflag_calc
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] r,
  input  logic         cout,
  input  logic [2:0]   opc,
  input  logic         wide,
  input  logic         cy_prev,
  output cond_t        nxt,
  output logic         known_op
);
  localparam int HW = W / 2;

  logic         is_add, is_sub, is_log, is_inc, is_dec, sub_like;
  logic [W-1:0] b_eff;
  logic         am, bm, rm;
  logic         unused_opnd;

  assign is_add   = (opc == OPC_ADD);
  assign is_sub   = (opc == OPC_SUB);
  assign is_log   = (opc == OPC_LOGIC);
  assign is_inc   = (opc == OPC_INC);
  assign is_dec   = (opc == OPC_DEC);
  assign sub_like = is_sub | is_dec;
  assign known_op = is_add | is_sub | is_log | is_inc | is_dec;

  assign b_eff = (is_inc | is_dec) ? W'(1) : b;
  assign am    = wide ? a[W-1]     : a[HW-1];
  assign bm    = wide ? b_eff[W-1] : b_eff[HW-1];
  assign rm    = wide ? r[W-1]     : r[HW-1];
  assign unused_opnd = ^{a, b};

  always_comb begin
    nxt.par = even_ones8(r[7:0]);
    nxt.zr  = wide ? (r == '0) : (r[HW-1:0] == '0);
    nxt.sg  = rm;
    if (is_log) begin
      nxt.cy = 1'b0;
      nxt.ov = 1'b0;
      nxt.ac = 1'b0;
    end else begin
      nxt.cy = (is_inc | is_dec) ? cy_prev : cout;
      nxt.ov = signed_ovf(sub_like, am, bm, rm);
      nxt.ac = a[NIB] ^ b_eff[NIB] ^ r[NIB];
    end
  end
endmodule

// File: rtl/aluflag_ctl.sv
module aluflag_ctl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_cmd,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] ctl_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          ctl_q[i] <= 1'b0;
      else if (set_cmd[i]) ctl_q[i] <= 1'b1;
      else if (clr_cmd[i]) ctl_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/aluflag_top.sv
module aluflag_top
  import aluflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] alu_result,
  input  logic         alu_cout,
  input  logic [2:0]   op_class,
  input  logic         wide_sel,
  input  logic         upd_en,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic [15:0]  flag_word
);
  cond_t            cond_q, cond_d;
  logic             known_op;
  logic             cond_we;
  logic [NCTL-1:0]  ctl_q;

  aluflag_calc #(.W(W)) u_calc (
    .a        (opnd_a),
    .b        (opnd_b),
    .r        (alu_result),
    .cout     (alu_cout),
    .opc      (op_class),
    .wide     (wide_sel),
    .cy_prev  (cond_q.cy),
    .nxt      (cond_d),
    .known_op (known_op)
  );

  assign cond_we = upd_en & known_op;

  always_ff @(posedge clk) begin
    if (!rst_n)       cond_q <= '0;
    else if (cond_we) cond_q <= cond_d;
  end

  aluflag_ctl #(.N(NCTL)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (ctl_set),
    .clr_cmd (ctl_clr),
    .ctl_q   (ctl_q)
  );

  always_comb begin
    flag_word          = '0;
    flag_word[B_ONE]   = 1'b1;
    flag_word[B_CY]    = cond_q.cy;
    flag_word[B_PAR]   = cond_q.par;
    flag_word[B_AC]    = cond_q.ac;
    flag_word[B_ZR]    = cond_q.zr;
    flag_word[B_SG]    = cond_q.sg;
    flag_word[B_OV]    = cond_q.ov;
    flag_word[B_TRAP]  = ctl_q[0];
    flag_word[B_INTEN] = ctl_q[1];
    flag_word[B_DIR]   = ctl_q[2];
  end
endmodule

// File: rtl/aluflag_chk.sv
module aluflag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_class,
  input logic        upd_en,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] flag_word
);
  // R10
  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[1] && flag_word[3] == 1'b0 && flag_word[5] == 1'b0 &&
    flag_word[15:12] == 4'h0);

  // R8
  a_r8_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en || op_class > 3'd4) |=>
      $stable({flag_word[11], flag_word[7:6], flag_word[4], flag_word[2], flag_word[0]}));

  // R2
  a_r2_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (op_class == 3'd3 || op_class == 3'd4)) |=> $stable(flag_word[0]));

  // R7 and R2
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd2) |=> (!flag_word[11] && !flag_word[0] && !flag_word[4]));

  // R9
  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flag_word[10:8]));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set != 3'b000) |=> ((flag_word[10:8] & $past(ctl_set)) == $past(ctl_set)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr != 3'b000) |=> ((flag_word[10:8] & $past(ctl_clr)) == 3'b000));
endmodule

bind aluflag_top aluflag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_class  (op_class),
  .upd_en    (upd_en),
  .ctl_set   (ctl_set),
  .ctl_clr   (ctl_clr),
  .flag_word (flag_word)
);

// File: tb/aluflag_top_bench.sv
module aluflag_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_result = '0;
  logic        alu_cout = 1'b0;
  logic [2:0]  op_class = 3'd0;
  logic        wide_sel = 1'b0, upd_en = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] flag_word;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  bit m_cf, m_pf, m_af, m_zf, m_sf, m_of;
  bit [2:0] m_ctl;

  always #5 clk = ~clk;

  aluflag_top u_aluflag_top (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_result(alu_result), .alu_cout(alu_cout), .op_class(op_class),
    .wide_sel(wide_sel), .upd_en(upd_en), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .flag_word(flag_word)
  );

  function automatic logic [15:0] model_word();
    logic [15:0] w;
    w = 16'h0002;
    w[0] = m_cf; w[2] = m_pf; w[4] = m_af; w[6] = m_zf; w[7] = m_sf;
    w[8] = m_ctl[0]; w[9] = m_ctl[1]; w[10] = m_ctl[2]; w[11] = m_of;
    return w;
  endfunction

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flag_word=%04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic drive(input int opc, input bit wd, input int a, input int b,
                       input bit upd, input logic [2:0] st, input logic [2:0] cl,
                       input string tag);
    int w, mask, half, av, bv, rv, sr;
    bit co, ovm, afm;
    w = wd ? 16 : 8;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    av = a & mask;
    bv = (opc == 3 || opc == 4) ? 1 : (b & mask);
    co = 1'b0; ovm = 1'b0; afm = 1'b0; sr = 0;
    case (opc)
      0, 3: begin
        rv = av + bv; co = ((rv >> w) & 1) != 0;
        sr = sx(av, w) + sx(bv, w);
        afm = ((av & 15) + (bv & 15)) > 15;
      end
      1, 4: begin
        rv = av - bv; co = av < bv;
        sr = sx(av, w) - sx(bv, w);
        afm = (av & 15) < (bv & 15);
      end
      default: rv = av ^ bv;
    endcase
    rv = rv & mask;
    ovm = (sr > half - 1) || (sr < -half);
    @(negedge clk);
    opnd_a = a[15:0];
    opnd_b = b[15:0];
    alu_result = wd ? rv[15:0] : {8'h5A ^ a[15:8], rv[7:0]};
    alu_cout = (opc == 3 || opc == 4) ? ~m_cf : co;
    op_class = opc[2:0];
    wide_sel = wd;
    upd_en = upd;
    ctl_set = st;
    ctl_clr = cl;
    if (upd && opc <= 4) begin
      m_pf = ($countones(rv & 255) % 2) == 0;
      m_zf = (rv == 0);
      m_sf = ((rv >> (w - 1)) & 1) != 0;
      if (opc == 2) begin m_cf = 0; m_of = 0; m_af = 0; end
      else begin
        m_of = ovm; m_af = afm;
        if (opc < 2) m_cf = co;
      end
    end
    for (int i = 0; i < 3; i++)
      if (st[i]) m_ctl[i] = 1'b1; else if (cl[i]) m_ctl[i] = 1'b0;
    sb_q.push_back('{model_word(), tag});
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(flag_word, it.exp, it.tag);
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: flag_word=%04h expected completion", flag_word);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(flag_word, 16'h0002, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check(flag_word, 16'h0002, "R1 after reset");
    // byte adds
    drive(0, 0, 'h0F, 'h01, 1, 0, 0, "R4 R3 add nibble carry");
    drive(0, 0, 'h7F, 'h01, 1, 0, 0, "R7 R6 byte signed ovf");
    drive(0, 0, 'hFF, 'h01, 1, 0, 0, "R2 R5 byte carry zero");
    drive(0, 0, 'h12, 'h34, 1, 0, 0, "R3 R10 plain add");
    // word adds
    drive(0, 1, 'h7FFF, 'h0001, 1, 0, 0, "R7 R6 word ovf");
    drive(0, 1, 'hFFFF, 'h0001, 1, 0, 0, "R2 R5 word carry zero");
    drive(0, 1, 'h00FF, 'h0001, 1, 0, 0, "R5 word nonzero low byte zero");
    drive(0, 1, 'h8000, 'h8000, 1, 0, 0, "R7 R2 neg ovf");
    // subtract
    drive(1, 0, 'h10, 'h01, 1, 0, 0, "R4 sub borrow nibble");
    drive(1, 0, 'h00, 'h01, 1, 0, 0, "R2 R6 sub borrow");
    drive(1, 0, 'h80, 'h01, 1, 0, 0, "R7 byte sub ovf");
    drive(1, 1, 'h1234, 'h1234, 1, 0, 0, "R5 sub zero");
    drive(1, 1, 'h0000, 'h8000, 1, 0, 0, "R7 word sub ovf");
    // inc / dec keep carry
    drive(0, 0, 'hFF, 'hFF, 1, 0, 0, "R2 set carry");
    drive(3, 0, 'h7F, 0, 1, 0, 0, "R2 R7 inc keeps carry");
    drive(4, 0, 'h00, 0, 1, 0, 0, "R2 R4 dec keeps carry");
    drive(1, 0, 'h05, 'h01, 1, 0, 0, "R2 clear carry");
    drive(3, 1, 'hFFFF, 0, 1, 0, 0, "R2 R5 inc wrap keeps carry");
    drive(4, 1, 'h8000, 0, 1, 0, 0, "R7 dec word ovf");
    // logic
    drive(0, 0, 'h7F, 'h01, 1, 0, 0, "R7 set ovf");
    drive(2, 0, 'hF0, 'h0F, 1, 0, 0, "R7 R2 logic clears");
    drive(2, 1, 'h1234, 'h1234, 1, 0, 0, "R5 R3 logic zero");
    drive(2, 1, 'h8001, 'h0000, 1, 0, 0, "R3 R6 logic odd parity");
    // hold cases
    drive(0, 0, 'hFF, 'h01, 0, 0, 0, "R8 upd_en low hold");
    drive(5, 0, 'hFF, 'h01, 1, 0, 0, "R8 op5 hold");
    drive(7, 1, 'h0000, 'h0000, 1, 0, 0, "R8 op7 hold");
    // control flags
    drive(0, 0, 'h01, 'h01, 1, 3'b001, 0, "R9 set trap");
    drive(0, 0, 'hFF, 'h01, 1, 3'b110, 0, "R9 set int dir");
    drive(2, 0, 'h00, 'h00, 1, 0, 0, "R9 alu no ctl effect");
    drive(0, 0, 'h00, 'h00, 0, 3'b010, 3'b011, "R9 set beats clear");
    drive(0, 0, 'h00, 'h00, 0, 0, 3'b101, "R9 clear");
    drive(1, 1, 'h0000, 'h0001, 1, 0, 3'b010, "R9 R10 clear int with alu");
    drive(0, 0, 'h00, 'h00, 0, 0, 0, "R10 idle");
    drive(0, 0, 'h00, 'h00, 0, 0, 0, "R10 idle");
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule